// File: doc/BRIEF.md
# Column-Parallel Word Multiply-Accumulate Row

This block forms the column sums of a schoolbook product of two unsigned operands that are each `WORDS` words of `WORD_W` bits (16 by default, so every word product fits a signed 18x18 hardware multiplier). Column k of the product is the sum of every word product a_i*b_j with i+j = k, and there are 2*WORDS-1 such columns. The row has `WORDS` multiply-accumulate lanes working side by side. One operand is broadcast one word at a time while the other rotates one word per cycle in the opposite sense, so that each lane sees a new word pair every cycle and accumulates whole columns in its own wide register.

Lane k first builds column k (k+1 products), hands it out and restarts its accumulator, and then builds column k+WORDS (WORDS-k-1 products). Every lane therefore does exactly WORDS multiplies in WORDS cycles. The low columns leave the row as they finish, one per cycle; the high columns all finish at the last multiply cycle and are drained one per cycle afterwards. The result is a gap-free stream of indexed column sums that a downstream adder can carry-propagate into the final product.

A host writes both operands with a one-cycle load strobe while the row is idle, then pulses start. The operand registers come back to their loaded contents at the end of each run, so start may be pulsed again without reloading.

Top module: `comba_mac_row`

## Requirements
- R1: After reset, busy and col_valid are low.
- R2: A load pulse while busy is low captures a_in and b_in; word i of each operand is bits [WORD_W*i+WORD_W-1 : WORD_W*i], and the next accepted start uses these values.
- R3: The value sent with index k equals the sum over all i+j = k (0 <= i,j < WORDS) of the unsigned word products a_i*b_j.
- R4: After a start is accepted, the columns 0 to 2*WORDS-2 appear on col_valid in ascending order, one per cycle with no gaps, the first one cycle after the start edge, each exactly once.
- R5: busy is high from the cycle after an accepted start until the cycle that carries the last column, and low in the cycle after it; a start pulse while busy is high is ignored.
- R6: A load pulse while busy is high has no effect on the current run or on the operands used by later runs.
- R7: Summing col_sum of column k shifted left by WORD_W*k bits over all columns gives the full product of the two operands.
- R8: A second start with no load in between produces the same column stream as the first.
- R9: With all operand words at their maximum, no column sum exceeds 2*WORD_W + clog2(WORDS) bits and none is lost to accumulator overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Capture a_in and b_in when idle |
| a_in | input | WORDS*WORD_W | First operand, word 0 in the low bits |
| b_in | input | WORDS*WORD_W | Second operand, word 0 in the low bits |
| start | input | 1 | Begin a multiply run when idle |
| busy | output | 1 | Run in progress or columns still leaving |
| col_valid | output | 1 | col_idx and col_sum carry a column this cycle |
| col_idx | output | clog2(2*WORDS-1) | Index of the column being sent |
| col_sum | output | ACC_W | Uncarried sum of that column |

## Verification
The hardest situation to reach is a lane switching from its low column to its high column, because the restart happens in a different cycle for every lane and the wrong restart cycle only shows in columns that mix both halves. The bench sweeps every pair of one-hot word positions in the two operands, so each single word product lands in exactly one column and a product counted in the wrong column or lost at a restart is caught individually. Random and all-ones operands add the carries and width extremes, and one run receives a foreign load and a second start in its middle, followed by a run with no reload, to show the operands and stream are untouched.

// File: rtl/comba_mac_row.sv
module comba_mac_row #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 16,
  parameter int ACC_W  = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [WORDS*WORD_W-1:0]   a_in,
  input  logic [WORDS*WORD_W-1:0]   b_in,
  input  logic                      start,
  output logic                      busy,
  output logic                      col_valid,
  output logic [$clog2(2*WORDS-1)-1:0] col_idx,
  output logic [ACC_W-1:0]          col_sum
);
  localparam int COLS   = 2*WORDS - 1;
  localparam int IDX_W  = $clog2(COLS);
  localparam int STEP_W = $clog2(WORDS);
  localparam int PROD_W = 2*WORD_W;

  typedef enum logic [1:0] {IDLE, RUN, DRAIN} state_t;

  state_t              state;
  logic [STEP_W-1:0]   step;
  logic [WORD_W-1:0]   a_rot  [WORDS];
  logic [WORD_W-1:0]   b_rot  [WORDS];
  logic [ACC_W-1:0]    acc    [WORDS];
  logic [ACC_W-1:0]    acc_nx [WORDS];

  assign busy = (state != IDLE) || col_valid;

  always_ff @(posedge clk) begin
    if (load && !busy) begin
      for (int i = 0; i < WORDS; i++) begin
        a_rot[i] <= a_in[i*WORD_W +: WORD_W];
        b_rot[i] <= b_in[i*WORD_W +: WORD_W];
      end
    end else if (state == RUN) begin
      for (int i = 0; i < WORDS; i++) begin
        a_rot[i] <= a_rot[(i+1) % WORDS];
        b_rot[i] <= b_rot[(i+WORDS-1) % WORDS];
      end
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_lane
    logic [PROD_W-1:0] prod;
    logic              fresh;
    assign prod      = a_rot[0] * b_rot[k];
    assign fresh     = (step == '0) || (32'(step) == k + 1);
    assign acc_nx[k] = fresh ? ACC_W'(prod) : acc[k] + ACC_W'(prod);

    always_ff @(posedge clk) begin
      if (!rst_n)             acc[k] <= '0;
      else if (state == RUN)  acc[k] <= acc_nx[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      step      <= '0;
      col_valid <= 1'b0;
      col_idx   <= '0;
      col_sum   <= '0;
    end else begin
      col_valid <= 1'b0;
      case (state)
        IDLE: if (start && !busy) begin
          state <= RUN;
          step  <= '0;
        end
        RUN: begin
          col_valid <= 1'b1;
          col_idx   <= IDX_W'(step);
          col_sum   <= acc_nx[step];
          if (step == STEP_W'(WORDS-1)) begin
            state <= DRAIN;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        DRAIN: begin
          col_valid <= 1'b1;
          col_idx   <= IDX_W'(WORDS) + IDX_W'(step);
          col_sum   <= acc[step];
          if (step == STEP_W'(WORDS-2)) begin
            state <= IDLE;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/comba_mac_row_chk.sv
module comba_mac_row_chk #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 16,
  parameter int ACC_W  = 48
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          start,
  input logic                          busy,
  input logic                          col_valid,
  input logic [$clog2(2*WORDS-1)-1:0]  col_idx,
  input logic [ACC_W-1:0]              col_sum
);
  localparam int SUM_W = 2*WORD_W + $clog2(WORDS);
  localparam int LAST  = 2*WORDS - 2;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !col_valid);                                              // R1
  AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_valid) |-> col_idx == '0);                                // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && $past(col_valid) |-> col_idx == $past(col_idx) + 1'b1); // R4
  AST_LAST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_idx == LAST |=> !col_valid);                       // R4
  AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col_valid) |-> $past(col_idx) == LAST);                       // R4
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !col_valid);                             // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> (col_sum >> SUM_W) == '0);                            // R9
endmodule

bind comba_mac_row comba_mac_row_chk #(.WORDS(WORDS), .WORD_W(WORD_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .col_valid(col_valid), .col_idx(col_idx), .col_sum(col_sum)
);

// File: tb/comba_mac_row_bench.sv
`timescale 1ns/1ps
module comba_mac_row_bench;
  localparam int WORDS  = 8;
  localparam int WORD_W = 16;
  localparam int ACC_W  = 48;
  localparam int OP_W   = WORDS*WORD_W;
  localparam int COLS   = 2*WORDS - 1;
  localparam int IDX_W  = $clog2(COLS);

  logic clk = 0, rst_n = 0, load = 0, start = 0;
  logic [OP_W-1:0] a_in = '0, b_in = '0;
  logic busy, col_valid;
  logic [IDX_W-1:0] col_idx;
  logic [ACC_W-1:0] col_sum;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  comba_mac_row #(.WORDS(WORDS), .WORD_W(WORD_W), .ACC_W(ACC_W)) u_comba_mac_row (
    .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_in), .b_in(b_in),
    .start(start), .busy(busy), .col_valid(col_valid),
    .col_idx(col_idx), .col_sum(col_sum));

  task automatic chk(input bit ok, input string req, input logic [2*OP_W+ACC_W-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ACC_W-1:0] col_exp(input logic [OP_W-1:0] a, b, input int k);
    logic [ACC_W-1:0] s = '0;
    for (int i = 0; i < WORDS; i++) begin
      int j = k - i;
      if (j >= 0 && j < WORDS)
        s += ACC_W'(a[i*WORD_W +: WORD_W]) * ACC_W'(b[j*WORD_W +: WORD_W]);
    end
    return s;
  endfunction

  task automatic do_load(input logic [OP_W-1:0] a, b);
    @(negedge clk); a_in = a; b_in = b; load = 1;
    @(negedge clk); load = 0;
  endtask

  // disturb: mid-run foreign load and second start (R5, R6)
  task automatic run_op(input logic [OP_W-1:0] a, b, input bit disturb);
    logic [2*OP_W+ACC_W-1:0] recon = '0;
    logic [2*OP_W+ACC_W-1:0] full;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy && !col_valid, "R5 busy after start", {busy, col_valid}, 2'b10);
    for (int c = 0; c < COLS; c++) begin
      if (disturb && c == 2) begin a_in = ~a; b_in = ~b; load = 1; start = 1; end
      @(negedge clk);
      load = 0; start = 0;
      chk(col_valid && busy && col_idx == IDX_W'(c), "R4 column order",
          {col_valid, col_idx}, {1'b1, IDX_W'(c)});
      chk(col_sum == col_exp(a, b, c), "R3 column sum", col_sum, col_exp(a, b, c));
      recon += (2*OP_W+ACC_W)'(col_sum) << (WORD_W*c);
    end
    full = (2*OP_W+ACC_W)'(a) * (2*OP_W+ACC_W)'(b);
    chk(recon == full, "R7 product", recon, full);
    @(negedge clk);
    chk(!col_valid && !busy, "R5 idle after last", {busy, col_valid}, 2'b00);
  endtask

  initial begin
    #(200000*5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [OP_W-1:0] ra, rb;
    repeat (3) @(negedge clk);
    chk(!busy && !col_valid, "R1 reset state", {busy, col_valid}, 2'b00);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !col_valid, "R1 idle after reset", {busy, col_valid}, 2'b00);

    do_load('0, '0);
    run_op('0, '0, 0);                          // R2 zeros
    do_load('1, '1);
    run_op('1, '1, 0);                          // R9 all-ones
    for (int i = 0; i < WORDS; i++)
      for (int j = 0; j < WORDS; j++) begin     // R3 one-hot sweep
        logic [OP_W-1:0] a = '0, b = '0;
        a[i*WORD_W +: WORD_W] = WORD_W'(16'hFFFF - i);
        b[j*WORD_W +: WORD_W] = WORD_W'(16'h8001 + j);
        do_load(a, b);
        run_op(a, b, 0);
      end
    for (int n = 0; n < 16; n++) begin          // R2 R7 random
      ra = '0; rb = '0;
      for (int w = 0; w < WORDS; w++) begin
        ra[w*WORD_W +: WORD_W] = WORD_W'($urandom);
        rb[w*WORD_W +: WORD_W] = WORD_W'($urandom);
      end
      do_load(ra, rb);
      run_op(ra, rb, n == 3);                   // R6 disturbed once
      if (n == 3) run_op(ra, rb, 0);            // R6 R8 no reload
    end
    run_op(ra, rb, 0);                          // R8 repeat start
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule